// File: doc/BRIEF.md
# Double-Buffered Down-Counting PWM Channel

This block is one channel of a pulse-width timer. A prescaler elsewhere supplies a one-clock tick enable, and the channel decrements a working counter on each tick. Two shadow values arrive as inputs: the period reload value and the compare threshold. They reach the working registers in only two ways. The first is an explicit load request. The second is an automatic reload when the counter expires while reload is enabled. Software can therefore stage a new period and duty without disturbing the waveform in flight.

The output pin is inactive after a reload and turns active once the counter is at or below the threshold. It then stays active until expiry, so a threshold of all ones holds the pin active for the whole period. A polarity bit flips the pin. Each expiry of a running channel produces a one-clock pulse. The channel's controls arrive as a 4-bit control nibble. A parameter selects the layout used by the final channel of a timer bank, which has no polarity bit and keeps its reload enable in a different position.

Top module: `pwm_db_channel`

## Requirements
- R1: Synchronous active-high `rst` clears the working count and threshold, the stopped state and `zero_pulse`. After reset with the nibble at invert-only (4'b0100), the pin reads 1 and `zero_pulse` reads 0.
- R2: While the load bit (nibble bit 1) is set, the working registers copy the shadow inputs on every clock, no count advances, no expiry pulse is produced and the pin is inactive. After the load bit clears with start (bit 0) and reload (bit 3) set, the first expiry pulse appears N clocks later when ticking every clock, where N = period value + 1.
- R3: A shadow-value change with no load and no expiry leaves the period in progress unchanged.
- R4: The counter decrements once per tick. With ticks on every clock, consecutive expiry pulses are N clocks apart, and each pulse is one clock wide.
- R5: At expiry with reload set, both working registers take the shadow values, so new values govern the next whole period.
- R6: If reload is cleared while the channel runs, the current period completes with one final pulse. The channel then stops at zero with the pin inactive and no further pulses until the next load.
- R7: Within a period the pin is active for min(C+1, N) ticks, where C is the threshold.
- R8: A threshold of all ones gives an active pin for every tick of the period.
- R9: The invert bit (nibble bit 2) flips the pin. A stopped channel shows the invert value on the pin.
- R10: With parameter `LAST_CHAN` set, reload is nibble bit 2, polarity is never inverted and bit 3 is ignored.
- R11: While `tick_en` is low, the counter, the pin and the pulse output hold.
- R12: Clearing start stops the channel at once. The pin goes inactive in the same cycle and no pulses follow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | One-clock count enable from the prescaler |
| ctrl_nib | input | 4 | Control nibble: start, load, invert, reload |
| period_shadow | input | CNT_W | Ticks per period minus one |
| thresh_shadow | input | CNT_W | Compare threshold |
| pwm_pin | output | 1 | Waveform output after polarity |
| zero_pulse | output | 1 | One-clock pulse on each expiry while running |

## Verification
The bench measures pulse spacing and active-tick counts over whole periods, including thresholds of zero, equal to the period value, above it and all ones. A design that compared with strict less-than or leaked partial periods would show counts off by one. Shadow values are swapped right after a reload. A design that applied them at once, instead of at the next expiry, would shorten or stretch the period in flight. Reload is cleared mid-period and ticks are paused; a design that stopped early, kept running or counted without ticks would show the wrong number of pulses. The final-channel layout is driven with the bit 3 reload request that it must ignore, so a design that read reload from the wrong position would keep running.

// File: rtl/pwm_pkg.sv
package pwm_pkg;

    localparam int CB_START       = 0;
    localparam int CB_LOAD        = 1;
    localparam int CB_INVERT      = 2;
    localparam int CB_RELOAD      = 3;
    localparam int CB_RELOAD_LAST = 2;

    typedef struct packed {
        logic start;
        logic load;
        logic invert;
        logic reload;
    } pwm_ctl_t;

    // Picks the nibble layout; the final bank channel has no polarity control.
    function automatic pwm_ctl_t decode_ctl(input logic [3:0] nib, input bit last_chan);
        pwm_ctl_t c;
        c.start = nib[CB_START];
        c.load  = nib[CB_LOAD];
        if (last_chan) begin
            c.invert = 1'b0;
            c.reload = nib[CB_RELOAD_LAST];
        end else begin
            c.invert = nib[CB_INVERT];
            c.reload = nib[CB_RELOAD];
        end
        return c;
    endfunction

endpackage

// File: rtl/pwm_down_counter.sv
module pwm_down_counter
    import pwm_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick_en,
    input  pwm_ctl_t         ctl,
    input  logic [CNT_W-1:0] period_shadow,
    input  logic [CNT_W-1:0] thresh_shadow,
    output logic [CNT_W-1:0] cnt_q,
    output logic [CNT_W-1:0] thr_q,
    output logic             halted_q,
    output logic             run,
    output logic             zero_pulse
);
    localparam logic [CNT_W-1:0] CNT_ZERO = '0;

    logic at_zero;

    assign at_zero = (cnt_q == CNT_ZERO);
    assign run     = ctl.start && !ctl.load && !halted_q;

    always_ff @(posedge clk) begin
        zero_pulse <= 1'b0;
        if (rst) begin
            cnt_q    <= '0;
            thr_q    <= '0;
            halted_q <= 1'b0;
        end else if (ctl.load) begin
            cnt_q    <= period_shadow;
            thr_q    <= thresh_shadow;
            halted_q <= 1'b0;
        end else if (run && tick_en) begin
            if (at_zero) begin
                zero_pulse <= 1'b1;
                if (ctl.reload) begin
                    cnt_q <= period_shadow;
                    thr_q <= thresh_shadow;
                end else begin
                    halted_q <= 1'b1;
                end
            end else begin
                cnt_q <= cnt_q - 1'b1;
            end
        end
    end

endmodule

// File: rtl/pwm_wave_out.sv
module pwm_wave_out #(
    parameter int CNT_W = 16
) (
    input  logic             run,
    input  logic             invert,
    input  logic [CNT_W-1:0] cnt_q,
    input  logic [CNT_W-1:0] thr_q,
    output logic             pin
);
    logic active;

    // At or below the threshold is the active part of the period.
    assign active = run && (cnt_q <= thr_q);
    assign pin    = active ^ invert;

endmodule

// File: rtl/pwm_db_channel.sv
module pwm_db_channel
    import pwm_pkg::*;
#(
    parameter int CNT_W     = 16,
    parameter bit LAST_CHAN = 1'b0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick_en,
    input  logic [3:0]       ctrl_nib,
    input  logic [CNT_W-1:0] period_shadow,
    input  logic [CNT_W-1:0] thresh_shadow,
    output logic             pwm_pin,
    output logic             zero_pulse
);
    pwm_ctl_t         ctl;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] thr_q;
    logic             halted_q;
    logic             run;

    always_comb ctl = decode_ctl(ctrl_nib, LAST_CHAN);

    pwm_down_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk           (clk),
        .rst           (rst),
        .tick_en       (tick_en),
        .ctl           (ctl),
        .period_shadow (period_shadow),
        .thresh_shadow (thresh_shadow),
        .cnt_q         (cnt_q),
        .thr_q         (thr_q),
        .halted_q      (halted_q),
        .run           (run),
        .zero_pulse    (zero_pulse)
    );

    pwm_wave_out #(.CNT_W(CNT_W)) u_wave (
        .run    (run),
        .invert (ctl.invert),
        .cnt_q  (cnt_q),
        .thr_q  (thr_q),
        .pin    (pwm_pin)
    );

endmodule

// File: rtl/pwm_db_channel_chk.sv
module pwm_db_channel_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst,
    input logic             tick_en,
    input logic             start,
    input logic             load,
    input logic             invert,
    input logic             halted_q,
    input logic [CNT_W-1:0] cnt_q,
    input logic [CNT_W-1:0] thr_q,
    input logic [CNT_W-1:0] period_shadow,
    input logic [CNT_W-1:0] thresh_shadow,
    input logic             pwm_pin,
    input logic             zero_pulse
);
    localparam logic [CNT_W-1:0] ALL_ONES = '1;
    localparam logic [CNT_W-1:0] CNT_ZERO = '0;

    logic running;
    assign running = start && !load && !halted_q;

    p_load_copies_r2: assert property (@(posedge clk) disable iff (rst)
        load |=> (cnt_q == $past(period_shadow)) && (thr_q == $past(thresh_shadow)));

    p_load_silent_r2: assert property (@(posedge clk) disable iff (rst)
        load |-> (pwm_pin == invert));

    p_count_down_r4: assert property (@(posedge clk) disable iff (rst)
        (running && tick_en && cnt_q != CNT_ZERO) |=> (cnt_q == $past(cnt_q) - 1'b1));

    p_pulse_width_r4: assert property (@(posedge clk) disable iff (rst)
        (zero_pulse && cnt_q != CNT_ZERO) |=> !zero_pulse);

    p_halt_inactive_r6: assert property (@(posedge clk) disable iff (rst)
        (halted_q && !load) |-> (pwm_pin == invert));

    p_full_duty_r8: assert property (@(posedge clk) disable iff (rst)
        (running && thr_q == ALL_ONES) |-> (pwm_pin != invert));

    p_hold_no_tick_r11: assert property (@(posedge clk) disable iff (rst)
        (!tick_en && !load) |=> $stable(cnt_q) && $stable(thr_q));

    p_stop_inactive_r12: assert property (@(posedge clk) disable iff (rst)
        !start |-> (pwm_pin == invert));

    p_no_pulse_idle_r12: assert property (@(posedge clk) disable iff (rst)
        zero_pulse |-> $past(start));

endmodule

bind pwm_db_channel pwm_db_channel_chk #(.CNT_W(CNT_W)) u_chk (
    .clk           (clk),
    .rst           (rst),
    .tick_en       (tick_en),
    .start         (ctl.start),
    .load          (ctl.load),
    .invert        (ctl.invert),
    .halted_q      (halted_q),
    .cnt_q         (cnt_q),
    .thr_q         (thr_q),
    .period_shadow (period_shadow),
    .thresh_shadow (thresh_shadow),
    .pwm_pin       (pwm_pin),
    .zero_pulse    (zero_pulse)
);

// File: tb/pwm_db_channel_bench.sv
module pwm_db_channel_bench;
    localparam int W = 16;
    localparam int NVEC = 7;
    // {period value, threshold}
    localparam logic [31:0] VECS [0:NVEC-1] = '{
        32'h0004_0001, 32'h0007_0000, 32'h0003_0003, 32'h0009_0006,
        32'h0002_FFFF, 32'h0005_000A, 32'h0001_0000
    };

    logic clk = 1'b0;
    logic rst, tick;
    logic [3:0] nib, nib_l;
    logic [W-1:0] pbuf, tbuf;
    logic pin, zp, pin_l, zp_l;
    int checks = 0, errors = 0;
    bit done = 0;

    always #5 clk = ~clk;

    pwm_db_channel #(.CNT_W(W), .LAST_CHAN(1'b0)) u_pwm_db_channel (
        .clk(clk), .rst(rst), .tick_en(tick), .ctrl_nib(nib),
        .period_shadow(pbuf), .thresh_shadow(tbuf), .pwm_pin(pin), .zero_pulse(zp));

    pwm_db_channel #(.CNT_W(W), .LAST_CHAN(1'b1)) u_pwm_db_channel_last (
        .clk(clk), .rst(rst), .tick_en(tick), .ctrl_nib(nib_l),
        .period_shadow(pbuf), .thresh_shadow(tbuf), .pwm_pin(pin_l), .zero_pulse(zp_l));

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic wait_pulse(input bit on_last, input int maxc, output int n);
        n = -1;
        for (int i = 1; i <= maxc; i++) begin
            step();
            if ((on_last ? zp_l : zp) == 1'b1) begin
                n = i;
                break;
            end
        end
    endtask

    // Called at a pulse cycle; returns at the next pulse cycle.
    task automatic measure(input bit on_last, input bit inv, output int per, output int act);
        act = (((on_last ? pin_l : pin) ^ inv) == 1'b1) ? 1 : 0;
        per = 1;
        for (int i = 0; i < 200; i++) begin
            step();
            if ((on_last ? zp_l : zp) == 1'b1) break;
            per++;
            if (((on_last ? pin_l : pin) ^ inv) == 1'b1) act++;
        end
    endtask

    task automatic count_pulses(input bit on_last, input int cyc, output int np);
        np = 0;
        for (int i = 0; i < cyc; i++) begin
            step();
            if ((on_last ? zp_l : zp) == 1'b1) np++;
        end
    endtask

    task automatic load_and_run(input logic [W-1:0] p, input logic [W-1:0] t, input bit inv);
        pbuf = p; tbuf = t;
        nib = {1'b0, inv, 2'b10};
        step();
        nib = {1'b1, inv, 2'b01};
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int n, per, act, np, expn, expa;
        logic prev;
        rst = 1'b1; tick = 1'b1; nib = 4'b0100; nib_l = 4'b0000;
        pbuf = '0; tbuf = '0;
        repeat (3) step();
        rst = 1'b0;
        step();
        // R1 / R9: stopped after reset, pin shows invert value
        chk(pin == 1'b1, "R1 pin after reset", int'(pin), 1);
        chk(zp == 1'b0, "R1 pulse after reset", int'(zp), 0);
        nib = 4'b0000; #1;
        chk(pin == 1'b0, "R9 stopped pin without invert", int'(pin), 0);
        step();

        // Vector table: R2 first pulse, R4 spacing, R7/R8 active ticks
        for (int v = 0; v < NVEC; v++) begin
            load_and_run(VECS[v][31:16], VECS[v][15:0], 1'b0);
            expn = int'(VECS[v][31:16]) + 1;
            expa = (VECS[v][15:0] >= VECS[v][31:16]) ? expn : int'(VECS[v][15:0]) + 1;
            wait_pulse(1'b0, 100, n);
            chk(n == expn, "R2 first pulse after load", n, expn);
            measure(1'b0, 1'b0, per, act);
            chk(per == expn, "R4 pulse spacing", per, expn);
            if (VECS[v][15:0] == 16'hFFFF)
                chk(act == expn, "R8 full duty", act, expn);
            else
                chk(act == expa, "R7 active ticks", act, expa);
            nib = 4'b0000;
            step();
        end

        // R3 / R5: shadow change mid-period applies only at next expiry
        load_and_run(16'd4, 16'd1, 1'b0);
        wait_pulse(1'b0, 100, n);
        pbuf = 16'd9; tbuf = 16'd2;
        measure(1'b0, 1'b0, per, act);
        chk(per == 5, "R3 current period kept", per, 5);
        chk(act == 2, "R3 current duty kept", act, 2);
        measure(1'b0, 1'b0, per, act);
        chk(per == 10, "R5 new period after reload", per, 10);
        chk(act == 3, "R5 new duty after reload", act, 3);
        nib = 4'b0000; step();

        // R9: inverted waveform
        load_and_run(16'd4, 16'd1, 1'b1);
        wait_pulse(1'b0, 100, n);
        measure(1'b0, 1'b1, per, act);
        chk(act == 2, "R9 inverted active (low) ticks", act, 2);
        nib = 4'b0100; step();
        chk(pin == 1'b1, "R9 stopped pin with invert", int'(pin), 1);
        nib = 4'b0000; step();

        // R2: load held while started -> no pulses, pin inactive
        load_and_run(16'd4, 16'd1, 1'b0);
        nib = 4'b1011;
        count_pulses(1'b0, 15, np);
        chk(np == 0, "R2 no pulse while loading", np, 0);
        chk(pin == 1'b0, "R2 pin inactive while loading", int'(pin), 0);
        nib = 4'b1001;
        wait_pulse(1'b0, 100, n);
        chk(n == 5, "R2 pulse after load release", n, 5);

        // R11: ticks paused
        tick = 1'b0;
        prev = pin;
        np = 0; n = 0;
        for (int i = 0; i < 20; i++) begin
            step();
            if (zp) np++;
            if (pin != prev) n++;
        end
        chk(np == 0, "R11 no pulse without ticks", np, 0);
        chk(n == 0, "R11 pin held without ticks", n, 0);
        tick = 1'b1;
        wait_pulse(1'b0, 100, n);
        chk(n == 5, "R11 resumes where held", n, 5);

        // R6: clear reload mid-period
        step(); step();
        nib = 4'b0001;
        count_pulses(1'b0, 30, np);
        chk(np == 1, "R6 one final pulse", np, 1);
        chk(pin == 1'b0, "R6 pin inactive when stopped", int'(pin), 0);
        nib = 4'b0000; step();

        // R12: clear start mid-period
        load_and_run(16'd9, 16'd9, 1'b0);
        step(); step();
        chk(pin == 1'b1, "R12 pin active before stop", int'(pin), 1);
        nib = 4'b0000; #1;
        chk(pin == 1'b0, "R12 pin inactive at stop", int'(pin), 0);
        count_pulses(1'b0, 20, np);
        chk(np == 0, "R12 no pulse after stop", np, 0);

        // R10: final-channel layout (reload at bit 2, no invert, bit 3 ignored)
        pbuf = 16'd2; tbuf = 16'd0;
        nib_l = 4'b0010; step();
        nib_l = 4'b0101;
        wait_pulse(1'b1, 100, n);
        chk(n == 3, "R10 last variant first pulse", n, 3);
        measure(1'b1, 1'b0, per, act);
        chk(per == 3, "R10 last variant reloads via bit 2", per, 3);
        nib_l = 4'b0100; #1;
        chk(pin_l == 1'b0, "R10 last variant bit 2 not invert", int'(pin_l), 0);
        nib_l = 4'b0010; step();
        nib_l = 4'b1001;
        count_pulses(1'b1, 20, np);
        chk(np == 1, "R10 last variant ignores bit 3", np, 1);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule